// File: doc/BRIEF.md
# Tag-Snooping Reservation Station

This block parks issued operations between issue and execution in an out-of-order core. Each operand arrives at issue either as a value or as the reorder-buffer index of the instruction that will produce it. A slot also records the reorder-buffer index of its own result. While an operand is missing, the slot watches the common result bus and takes the value when the broadcast index matches the operand's producer index. This resolves read-after-write hazards without naming station slots anywhere.

Once a slot is ready, it is offered to a single functional unit through a valid/ready handshake. Among the ready slots, the oldest by allocation order goes first. A non-store operation needs both operands. A store needs only its base operand, because its dispatch computes only the effective address, and its data operand may still be pending. A dispatched slot stays occupied until a broadcast carries its own result index, and that broadcast frees it. A flush input empties every slot at once.

Top module: `rs_station`

## Requirements
- R1: `full` is high exactly when all ENTRIES slots are occupied. An issue presented while `full` is high is ignored and never dispatched.
- R2: An operand marked ready at issue (`iss_a_rdy`/`iss_b_rdy` = 1) is held as the given value and is delivered unchanged on dispatch.
- R3: A pending operand is filled from the result bus when `cdb_valid` is high and `cdb_tag` equals its producer index. A broadcast with any other index leaves it pending.
- R4: If the result bus broadcasts an operand's producer index in the same cycle that operand is issued as pending, the broadcast value is captured.
- R5: A non-store operation (`iss_store` = 0) is not dispatched until both operands are ready. On dispatch, `dsp_b_rdy` is 1.
- R6: A store (`iss_store` = 1) is dispatched once its base operand (operand A) is ready. If its data operand is still pending, it goes out with `dsp_b_rdy` = 0 and the producer index on `dsp_b_tag`.
- R7: A dispatch presents the slot's own result index on `dsp_dst`. The slot stays occupied after dispatch until a broadcast with that index arrives, and is then freed.
- R8: When several slots are ready, the one allocated earliest is dispatched first.
- R9: At most one operation is handed off per cycle. While `dsp_valid` is high and `dsp_ready` is low, the offered operation stays the same, even if an older slot becomes ready.
- R10: `flush` empties all slots. The cycle after it, `dsp_valid` and `full` are 0, and later broadcasts dispatch nothing from the flushed slots.
- R11: After reset, `dsp_valid` and `full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_store | input | 1 | Operation is a store |
| iss_dst | input | TAG_W | Reorder-buffer index of this result |
| iss_a_rdy | input | 1 | Operand A is supplied as a value |
| iss_a_val | input | DATA_W | Operand A value |
| iss_a_tag | input | TAG_W | Operand A producer index |
| iss_b_rdy | input | 1 | Operand B is supplied as a value |
| iss_b_val | input | DATA_W | Operand B value |
| iss_b_tag | input | TAG_W | Operand B producer index |
| full | output | 1 | No free slot |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Broadcast reorder-buffer index |
| cdb_data | input | DATA_W | Broadcast value |
| dsp_valid | output | 1 | Operation offered to the unit |
| dsp_ready | input | 1 | Unit accepts the offer |
| dsp_op | output | OP_W | Operation code |
| dsp_is_store | output | 1 | Offered operation is a store |
| dsp_dst | output | TAG_W | Result index |
| dsp_a | output | DATA_W | Operand A |
| dsp_b_rdy | output | 1 | Operand B is valid |
| dsp_b | output | DATA_W | Operand B value |
| dsp_b_tag | output | TAG_W | Operand B producer index |

## Verification
Issue and the result bus can act in the same cycle, and the bench provokes this twice. In the first case, it issues an operation whose operand waits on an index while that same index is broadcast. The operation must then dispatch with the broadcast value, not stall forever. In the second case, it stalls the unit while a broadcast wakes an older slot, and judges at the ports that the offered operation does not change until it is accepted, after which the woken older slot precedes a younger ready one.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_SENT = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_alloc_sel.sv
module rs_alloc_sel #(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0] busy,
  output logic [ENTRIES-1:0] free_oh,
  output logic               any_free
);
  always_comb begin
    free_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy[i]) free_oh = ENTRIES'(1) << i;
    end
    any_free = |free_oh;
  end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [ENTRIES-1:0] alloc_oh,
  input  logic [ENTRIES-1:0] ready,
  input  logic               take,
  output logic [ENTRIES-1:0] grant,
  output logic               grant_any
);
  // older_q[j][i] = 1 : slot j was allocated before slot i
  logic [ENTRIES-1:0] older_q [ENTRIES];
  logic [ENTRIES-1:0] pick;
  logic               lock_q;
  logic [ENTRIES-1:0] lock_oh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ENTRIES; j++) older_q[j] <= '0;
    end else begin
      for (int k = 0; k < ENTRIES; k++) begin
        if (alloc_oh[k]) begin
          for (int j = 0; j < ENTRIES; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      pick[i] = ready[i];
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && ready[j] && older_q[j][i]) pick[i] = 1'b0;
      end
    end
    grant     = lock_q ? lock_oh_q : pick;
    grant_any = |grant;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      lock_q    <= 1'b0;
      lock_oh_q <= '0;
    end else begin
      lock_q    <= grant_any && !take;
      lock_oh_q <= grant;
    end
  end

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_grant_is_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (grant & ~ready) == '0);
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              alloc,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_store,
  input  logic [TAG_W-1:0]  in_dst,
  input  logic              in_a_rdy,
  input  logic [DATA_W-1:0] in_a_val,
  input  logic [TAG_W-1:0]  in_a_tag,
  input  logic              in_b_rdy,
  input  logic [DATA_W-1:0] in_b_val,
  input  logic [TAG_W-1:0]  in_b_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              fire,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic              is_store,
  output logic [TAG_W-1:0]  dst,
  output logic [DATA_W-1:0] a_val,
  output logic              b_rdy,
  output logic [DATA_W-1:0] b_val,
  output logic [TAG_W-1:0]  b_tag
);
  slot_state_e       st_q;
  logic              a_rdy_q;
  logic [TAG_W-1:0]  a_tag_q;
  logic              in_a_hit, in_b_hit, a_hit, b_hit, own_hit;

  assign in_a_hit = cdb_valid && (cdb_tag == in_a_tag);
  assign in_b_hit = cdb_valid && (cdb_tag == in_b_tag);
  assign a_hit    = cdb_valid && !a_rdy_q && (cdb_tag == a_tag_q);
  assign b_hit    = cdb_valid && !b_rdy && (cdb_tag == b_tag);
  assign own_hit  = cdb_valid && (cdb_tag == dst);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st_q <= SLOT_FREE;
    end else begin
      unique case (st_q)
        SLOT_FREE: if (alloc)   st_q <= SLOT_WAIT;
        SLOT_WAIT: if (fire)    st_q <= SLOT_SENT;
        SLOT_SENT: if (own_hit) st_q <= SLOT_FREE;
        default:                st_q <= SLOT_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdy_q <= 1'b0;
      b_rdy   <= 1'b0;
    end else if (alloc) begin
      op       <= in_op;
      is_store <= in_store;
      dst      <= in_dst;
      a_tag_q  <= in_a_tag;
      b_tag    <= in_b_tag;
      a_rdy_q  <= in_a_rdy || in_a_hit;
      a_val    <= in_a_rdy ? in_a_val : cdb_data;
      b_rdy    <= in_b_rdy || in_b_hit;
      b_val    <= in_b_rdy ? in_b_val : cdb_data;
    end else if (st_q != SLOT_FREE) begin
      if (a_hit) begin
        a_rdy_q <= 1'b1;
        a_val   <= cdb_data;
      end
      if (b_hit) begin
        b_rdy <= 1'b1;
        b_val <= cdb_data;
      end
    end
  end

  assign busy  = (st_q != SLOT_FREE);
  assign ready = (st_q == SLOT_WAIT) && a_rdy_q && (is_store || b_rdy);

  p_no_free_unsent_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_WAIT && !fire && !flush) |=> (st_q == SLOT_WAIT));
  p_capture_a_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && a_hit && !alloc && !flush) |=> (a_rdy_q && a_val == $past(cdb_data)));
  p_fire_ready_r5: assert property (@(posedge clk) disable iff (rst)
    fire |-> ready);
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int OP_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic              iss_store,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              iss_a_rdy,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic              iss_b_rdy,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  output logic              full,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [OP_W-1:0]   dsp_op,
  output logic              dsp_is_store,
  output logic [TAG_W-1:0]  dsp_dst,
  output logic [DATA_W-1:0] dsp_a,
  output logic              dsp_b_rdy,
  output logic [DATA_W-1:0] dsp_b,
  output logic [TAG_W-1:0]  dsp_b_tag
);
  logic [ENTRIES-1:0] busy, ready, free_oh, alloc_oh, grant, fire;
  logic               any_free, grant_any, take;
  logic [OP_W-1:0]    s_op    [ENTRIES];
  logic               s_st    [ENTRIES];
  logic [TAG_W-1:0]   s_dst   [ENTRIES];
  logic [DATA_W-1:0]  s_a     [ENTRIES];
  logic               s_b_rdy [ENTRIES];
  logic [DATA_W-1:0]  s_b     [ENTRIES];
  logic [TAG_W-1:0]   s_b_tag [ENTRIES];

  rs_alloc_sel #(.ENTRIES(ENTRIES)) u_alloc (
    .busy(busy), .free_oh(free_oh), .any_free(any_free)
  );

  assign alloc_oh = (iss_valid && !flush) ? free_oh : '0;
  assign take     = grant_any && dsp_ready;
  assign fire     = take ? grant : '0;

  rs_age_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk(clk), .rst(rst), .flush(flush), .alloc_oh(alloc_oh),
    .ready(ready), .take(dsp_ready), .grant(grant), .grant_any(grant_any)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_slot (
      .clk(clk), .rst(rst), .flush(flush), .alloc(alloc_oh[i]),
      .in_op(iss_op), .in_store(iss_store), .in_dst(iss_dst),
      .in_a_rdy(iss_a_rdy), .in_a_val(iss_a_val), .in_a_tag(iss_a_tag),
      .in_b_rdy(iss_b_rdy), .in_b_val(iss_b_val), .in_b_tag(iss_b_tag),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .fire(fire[i]), .busy(busy[i]), .ready(ready[i]),
      .op(s_op[i]), .is_store(s_st[i]), .dst(s_dst[i]), .a_val(s_a[i]),
      .b_rdy(s_b_rdy[i]), .b_val(s_b[i]), .b_tag(s_b_tag[i])
    );
  end

  always_comb begin
    dsp_op       = '0;
    dsp_is_store = 1'b0;
    dsp_dst      = '0;
    dsp_a        = '0;
    dsp_b_rdy    = 1'b0;
    dsp_b        = '0;
    dsp_b_tag    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        dsp_op       = s_op[i];
        dsp_is_store = s_st[i];
        dsp_dst      = s_dst[i];
        dsp_a        = s_a[i];
        dsp_b_rdy    = s_b_rdy[i];
        dsp_b        = s_b[i];
        dsp_b_tag    = s_b_tag[i];
      end
    end
  end

  assign dsp_valid = grant_any;
  assign full      = !any_free;

  p_hold_offer_r9: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid && !dsp_ready && !flush) |=>
      (dsp_valid && $stable(dsp_dst) && $stable(dsp_a)));
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!dsp_valid && !full));
  p_nonstore_both_r5: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid && !dsp_is_store) |-> dsp_b_rdy);
  p_no_alloc_when_full_r1: assert property (@(posedge clk) disable iff (rst)
    (alloc_oh & busy) == '0);
endmodule

// File: tb/rs_station_bench.sv
module rs_station_bench;
  localparam int DW = 32, TW = 4, OW = 4;

  logic clk = 0, rst = 1, flush = 0;
  logic iss_valid = 0, iss_store = 0, iss_a_rdy = 0, iss_b_rdy = 0;
  logic [OW-1:0] iss_op = 0;
  logic [TW-1:0] iss_dst = 0, iss_a_tag = 0, iss_b_tag = 0;
  logic [DW-1:0] iss_a_val = 0, iss_b_val = 0;
  logic cdb_valid = 0;
  logic [TW-1:0] cdb_tag = 0;
  logic [DW-1:0] cdb_data = 0;
  logic dsp_ready = 0;
  logic full, dsp_valid, dsp_is_store, dsp_b_rdy;
  logic [OW-1:0] dsp_op;
  logic [TW-1:0] dsp_dst, dsp_b_tag;
  logic [DW-1:0] dsp_a, dsp_b;

  always #2 clk = ~clk;

  rs_station u_rs_station (
    .clk(clk), .rst(rst), .flush(flush), .iss_valid(iss_valid),
    .iss_op(iss_op), .iss_store(iss_store), .iss_dst(iss_dst),
    .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
    .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
    .full(full), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
    .dsp_is_store(dsp_is_store), .dsp_dst(dsp_dst), .dsp_a(dsp_a),
    .dsp_b_rdy(dsp_b_rdy), .dsp_b(dsp_b), .dsp_b_tag(dsp_b_tag)
  );

  typedef struct {
    logic [OW-1:0] op;
    logic          st;
    logic [TW-1:0] dst;
    logic [DW-1:0] a;
    logic          b_rdy;
    logic [DW-1:0] b;
    logic [TW-1:0] b_tag;
    string         req;
  } item_t;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input logic [OW-1:0] op, input logic st, input logic [TW-1:0] dst,
                             input logic [DW-1:0] a, input logic b_rdy, input logic [DW-1:0] b,
                             input logic [TW-1:0] b_tag, input string req);
    item_t it;
    it.op = op; it.st = st; it.dst = dst; it.a = a;
    it.b_rdy = b_rdy; it.b = b; it.b_tag = b_tag; it.req = req;
    exp_q.push_back(it);
  endtask

  // Monitor: every accepted dispatch is compared with the queue head
  always @(negedge clk) begin
    if (!rst && dsp_valid && dsp_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R1/R10 unexpected dispatch", dsp_dst, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(dsp_dst == it.dst, {it.req, " dst"}, dsp_dst, it.dst);
        check(dsp_op == it.op && dsp_is_store == it.st, {it.req, " op"}, {dsp_is_store, dsp_op}, {it.st, it.op});
        check(dsp_a == it.a, {it.req, " a"}, dsp_a, it.a);
        check(dsp_b_rdy == it.b_rdy, {it.req, " b_rdy"}, dsp_b_rdy, it.b_rdy);
        if (it.b_rdy) check(dsp_b == it.b, {it.req, " b"}, dsp_b, it.b);
        else          check(dsp_b_tag == it.b_tag, {it.req, " b_tag"}, dsp_b_tag, it.b_tag);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive_issue(input logic [OW-1:0] op, input logic st, input logic [TW-1:0] dst,
                             input logic ar, input logic [DW-1:0] av, input logic [TW-1:0] at,
                             input logic br, input logic [DW-1:0] bv, input logic [TW-1:0] bt);
    iss_valid = 1; iss_op = op; iss_store = st; iss_dst = dst;
    iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
    iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
  endtask

  task automatic issue(input logic [OW-1:0] op, input logic st, input logic [TW-1:0] dst,
                       input logic ar, input logic [DW-1:0] av, input logic [TW-1:0] at,
                       input logic br, input logic [DW-1:0] bv, input logic [TW-1:0] bt);
    step();
    drive_issue(op, st, dst, ar, av, at, br, bv, bt);
    step();
    iss_valid = 0;
  endtask

  task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] data);
    step();
    cdb_valid = 1; cdb_tag = tag; cdb_data = data;
    step();
    cdb_valid = 0;
  endtask

  task automatic set_ready(input logic r);
    step();
    dsp_ready = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check(0, "watchdog", cycles, 100000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    check(dsp_valid == 0, "R11 dsp_valid", dsp_valid, 0);
    check(full == 0, "R11 full", full, 0);

    // R2: both operands given as values
    set_ready(1);
    expect_item(4'h1, 0, 4'd3, 32'd10, 1, 32'd20, 4'd0, "R2");
    issue(4'h1, 0, 4'd3, 1, 32'd10, 4'd0, 1, 32'd20, 4'd0);
    idle(2);
    bcast(4'd3, 32'h33);

    // R8/R9/R3: stalled unit, older slot woken late
    set_ready(0);
    issue(4'h2, 0, 4'd5, 0, 32'd0, 4'd9, 1, 32'd50, 4'd0);
    issue(4'h3, 0, 4'd6, 1, 32'd60, 4'd0, 1, 32'd61, 4'd0);
    issue(4'h4, 0, 4'd7, 1, 32'd70, 4'd0, 1, 32'd71, 4'd0);
    bcast(4'd9, 32'd99);
    idle(1);
    @(negedge clk);
    check(dsp_valid == 1 && dsp_dst == 4'd6, "R9 offer held", dsp_dst, 6);
    expect_item(4'h3, 0, 4'd6, 32'd60, 1, 32'd61, 4'd0, "R9");
    expect_item(4'h2, 0, 4'd5, 32'd99, 1, 32'd50, 4'd0, "R8 R3");
    expect_item(4'h4, 0, 4'd7, 32'd70, 1, 32'd71, 4'd0, "R8");
    set_ready(1);
    idle(4);
    bcast(4'd5, 0); bcast(4'd6, 0); bcast(4'd7, 0);

    // R3: non-matching broadcast leaves operand pending
    issue(4'h5, 0, 4'd4, 0, 32'd0, 4'd12, 1, 32'd44, 4'd0);
    bcast(4'd13, 32'hdead);
    @(negedge clk);
    check(dsp_valid == 0, "R3 nonmatching tag", dsp_valid, 0);
    expect_item(4'h5, 0, 4'd4, 32'h1212, 1, 32'd44, 4'd0, "R3");
    bcast(4'd12, 32'h1212);
    idle(2);
    bcast(4'd4, 0);

    // R4: issue and matching broadcast in the same cycle
    expect_item(4'h6, 0, 4'd8, 32'h55, 1, 32'd7, 4'd0, "R4");
    step();
    drive_issue(4'h6, 0, 4'd8, 0, 32'd0, 4'd14, 1, 32'd7, 4'd0);
    cdb_valid = 1; cdb_tag = 4'd14; cdb_data = 32'h55;
    step();
    iss_valid = 0; cdb_valid = 0;
    idle(3);
    bcast(4'd8, 0);

    // R6: store goes out with only the base ready
    expect_item(4'h7, 1, 4'd10, 32'h100, 0, 32'd0, 4'd2, "R6");
    issue(4'h7, 1, 4'd10, 1, 32'h100, 4'd0, 0, 32'd0, 4'd2);
    idle(3);
    bcast(4'd10, 0);

    // R5: non-store waits for operand B
    issue(4'h8, 0, 4'd11, 1, 32'd1, 4'd0, 0, 32'd0, 4'd8);
    idle(2);
    @(negedge clk);
    check(dsp_valid == 0, "R5 waits for B", dsp_valid, 0);
    expect_item(4'h8, 0, 4'd11, 32'd1, 1, 32'h88, 4'd0, "R5");
    bcast(4'd8, 32'h88);
    idle(3);
    bcast(4'd11, 0);

    // R7: dispatched slots stay occupied until their own result
    for (int i = 1; i <= 4; i++) begin
      expect_item(4'h9, 0, 4'(i), 32'(i), 1, 32'(i + 100), 4'd0, "R7");
      issue(4'h9, 0, 4'(i), 1, 32'(i), 4'd0, 1, 32'(i + 100), 4'd0);
    end
    idle(4);
    @(negedge clk);
    check(full == 1, "R7 held after dispatch", full, 1);
    bcast(4'd1, 0);
    @(negedge clk);
    check(full == 0, "R7 freed by own result", full, 0);
    bcast(4'd2, 0); bcast(4'd3, 0); bcast(4'd4, 0);

    // R1: fill with waiting slots, then an ignored issue
    for (int i = 1; i <= 4; i++) issue(4'ha, 0, 4'(i), 0, 32'd0, 4'd11, 1, 32'd0, 4'd0);
    @(negedge clk);
    check(full == 1, "R1 full", full, 1);
    issue(4'hb, 0, 4'd15, 1, 32'd1, 4'd0, 1, 32'd2, 4'd0);
    idle(2);
    @(negedge clk);
    check(dsp_valid == 0, "R1 issue while full ignored", dsp_valid, 0);

    // R10: flush
    step();
    flush = 1;
    step();
    flush = 0;
    @(negedge clk);
    check(full == 0, "R10 full after flush", full, 0);
    check(dsp_valid == 0, "R10 valid after flush", dsp_valid, 0);
    bcast(4'd11, 32'h11);
    idle(1);
    @(negedge clk);
    check(dsp_valid == 0, "R10 flushed slots stay gone", dsp_valid, 0);
    expect_item(4'hc, 0, 4'd9, 32'd3, 1, 32'd4, 4'd0, "R10 after flush");
    issue(4'hc, 0, 4'd9, 1, 32'd3, 4'd0, 1, 32'd4, 4'd0);
    idle(3);
    bcast(4'd9, 0);

    idle(4);
    check(exp_q.size() == 0, "R8 all expected dispatched", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule